// File: doc/BRIEF.md
# Multi-Vector Replicated Add into Accumulator Rows

This unit executes one instruction form: a lane-wise integer add that takes a group of two or four consecutive vector registers and adds one shared vector to each member. Every sum is written into its own row of an accumulator array. A 32-bit instruction word is decoded when `start` is pulsed. The unit reads a select register and the source vectors in that cycle, then writes one destination row per clock. `done` pulses with the last row. Words that do not fit the encoding raise `illegal`. A 64-bit-lane request on a build without 64-bit support raises `undef`. In both cases nothing is written.

The block holds the vector register file (32 registers of `VL` bits), four 32-bit select registers and an accumulator array of `VL/8` rows. Each of these has a direct write port and a direct read port, so that an environment can preload state and inspect results. The destination rows are spread across the array. The array is split into two halves or four quarters, one per group member. The row inside each part is the select value plus a 3-bit immediate, reduced modulo the part size.

Top module: `mvec_add_unit`

## Requirements
- R1: A word is accepted only if bits 31..23 = 110000010, bit 15 = 0, bits 12..10 = 110 and bits 4..3 = 10. Any other word sets `illegal` and gives a `done` pulse in the cycle after `start`. `busy` stays low and no accumulator row changes.
- R2: Bits 21..20 = 10 selects a group of two sources and two destination rows. 11 selects four of each. 00 and 01 are treated as in R1.
- R3: Bit 22 selects the lane width: 0 gives 32-bit lanes and 1 gives 64-bit lanes. Each lane sum wraps modulo 2^width, with no carry into the next lane.
- R4: Bits 14..13 pick select register 0..3 (the architectural registers 8..11). All 32 bits of that register are used.
- R5: With stride = (VL/8)/group size, the first row is (select value + bits 2..0) mod stride, computed without 32-bit overflow loss. Member r goes to first row + r*stride.
- R6: Member r reads vector register (bits 9..5 + r) mod 32. The shared operand is register {0, bits 19..16}, so it is always one of registers 0..15.
- R7: A destination row is overwritten with the sum and does not accumulate. All other rows keep their contents.
- R8: When bit 22 = 1 and the `SUPPORT_64` parameter is 0, `undef` is set, `done` pulses in the cycle after `start`, and no row is written.
- R9: After an accepted `start`, `busy` is high and member r's row is visible r+1 cycles later. `done` is a single-cycle pulse that appears with the last row as `busy` falls. A `start` while `busy` is ignored.
- R10: The select value and all source vectors are sampled in the `start` cycle. Later writes to the register file or the select registers do not change the result.
- R11: Reset (synchronous, active high) clears `busy`, `done`, `illegal`, `undef`, every vector register, every select register and every accumulator row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin executing `instr` |
| instr | input | 32 | Instruction word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last word did not match the encoding |
| undef | output | 1 | Last word asked for unsupported 64-bit lanes |
| zr_we | input | 1 | Vector register write enable |
| zr_waddr | input | 5 | Vector register write index |
| zr_wdata | input | VL | Vector register write data |
| zr_raddr | input | 5 | Vector register read index |
| zr_rdata | output | VL | Vector register read data |
| sel_we | input | 1 | Select register write enable |
| sel_waddr | input | 2 | Select register write index |
| sel_wdata | input | 32 | Select register write data |
| sel_raddr | input | 2 | Select register read index |
| sel_rdata | output | 32 | Select register read data |
| acc_we | input | 1 | Accumulator row write enable (the unit's own write wins) |
| acc_waddr | input | log2(VL/8) | Accumulator row write index |
| acc_wdata | input | VL | Accumulator row write data |
| acc_raddr | input | log2(VL/8) | Accumulator row read index |
| acc_rdata | output | VL | Accumulator row read data |

## Verification
The hardest case to reach from the ports is a change of operand state while an operation is still running. The stimulus handles this by overwriting the first source register and the chosen select register, and by raising `start` again with a different word, in the cycle right after the operation is accepted. The sum must still reflect the values captured at start. The sweep also drives select values next to 2^32 and source groups that begin at registers 30 and 31, so that both wrap paths are exercised.

// File: rtl/vadd_pkg.sv
package vadd_pkg;

    localparam logic [8:0] FIX_TOP  = 9'b110000010;
    localparam logic [2:0] FIX_MID  = 3'b110;
    localparam logic [1:0] FIX_LOW  = 2'b10;

    typedef struct packed {
        logic       match;
        logic       quad;
        logic       wide;
        logic [3:0] zm;
        logic [1:0] rv;
        logic [4:0] zn;
        logic [2:0] off;
    } vadd_dec_t;

    function automatic vadd_dec_t vadd_decode(input logic [31:0] w);
        vadd_dec_t d;
        d.match = (w[31:23] == FIX_TOP) && w[21] && !w[15] &&
                  (w[12:10] == FIX_MID) && (w[4:3] == FIX_LOW);
        d.quad  = w[20];
        d.wide  = w[22];
        d.zm    = w[19:16];
        d.rv    = w[14:13];
        d.zn    = w[9:5];
        d.off   = w[2:0];
        return d;
    endfunction

endpackage

// File: rtl/vadd_bank.sv
module vadd_bank #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 128,
    parameter int NRD   = 1,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [WIDTH-1:0]           wdata,
    input  logic [NRD-1:0][AW-1:0]     raddr,
    output logic [NRD-1:0][WIDTH-1:0]  rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/vadd_lane_add.sv
module vadd_lane_add #(
    parameter int VL = 128
) (
    input  logic [VL-1:0] a,
    input  logic [VL-1:0] b,
    input  logic          wide,
    output logic [VL-1:0] sum
);
    localparam int NCH = VL / 64;

    // Each 64-bit chunk is two 32-bit adders; the middle carry is passed on only for wide lanes.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [32:0] lo;
        logic [31:0] hi;
        assign lo = {1'b0, a[c*64 +: 32]} + {1'b0, b[c*64 +: 32]};
        assign hi = a[c*64+32 +: 32] + b[c*64+32 +: 32] + {31'b0, wide & lo[32]};
        assign sum[c*64 +: 64] = {hi, lo[31:0]};
    end
endmodule

// File: rtl/mvec_add_unit.sv
module mvec_add_unit
    import vadd_pkg::*;
#(
    parameter int VL         = 128,   // power of two, at least 64
    parameter bit SUPPORT_64 = 1'b1,
    localparam int ROWS      = VL / 8,
    localparam int ROW_W     = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [31:0]      instr,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic             undef,
    input  logic             zr_we,
    input  logic [4:0]       zr_waddr,
    input  logic [VL-1:0]    zr_wdata,
    input  logic [4:0]       zr_raddr,
    output logic [VL-1:0]    zr_rdata,
    input  logic             sel_we,
    input  logic [1:0]       sel_waddr,
    input  logic [31:0]      sel_wdata,
    input  logic [1:0]       sel_raddr,
    output logic [31:0]      sel_rdata,
    input  logic             acc_we,
    input  logic [ROW_W-1:0] acc_waddr,
    input  logic [VL-1:0]    acc_wdata,
    input  logic [ROW_W-1:0] acc_raddr,
    output logic [VL-1:0]    acc_rdata
);
    localparam int MAXG  = 4;
    localparam int ZRD   = MAXG + 2;

    vadd_dec_t dec;
    assign dec = vadd_decode(instr);

    logic accept, go;
    logic busy_q, done_q, illegal_q, undef_q, wide_q;
    logic [1:0] step_q, last_q;
    logic [ROW_W-1:0] start_row_q, stride_q, row;
    logic [VL-1:0] src_q [MAXG];
    logic [VL-1:0] zm_q, sum;

    assign accept = start && !busy_q;
    assign go     = accept && dec.match && !(dec.wide && !SUPPORT_64);

    // Vector register file: group reads, shared operand, external read
    logic [ZRD-1:0][4:0]    zr_ra;
    logic [ZRD-1:0][VL-1:0] zr_rd;
    for (genvar k = 0; k < MAXG; k++) begin : g_src_ra
        assign zr_ra[k] = dec.zn + 5'(k);
    end
    assign zr_ra[MAXG]   = {1'b0, dec.zm};
    assign zr_ra[MAXG+1] = zr_raddr;
    assign zr_rdata      = zr_rd[MAXG+1];

    vadd_bank #(.DEPTH(32), .WIDTH(VL), .NRD(ZRD)) u_zr (
        .clk(clk), .rst(rst), .we(zr_we), .waddr(zr_waddr), .wdata(zr_wdata),
        .raddr(zr_ra), .rdata(zr_rd)
    );

    // Select registers
    logic [1:0][1:0]  sel_ra;
    logic [1:0][31:0] sel_rd;
    assign sel_ra    = {sel_raddr, dec.rv};
    assign sel_rdata = sel_rd[1];

    vadd_bank #(.DEPTH(4), .WIDTH(32), .NRD(2)) u_sel (
        .clk(clk), .rst(rst), .we(sel_we), .waddr(sel_waddr), .wdata(sel_wdata),
        .raddr(sel_ra), .rdata(sel_rd)
    );

    // First row: power-of-two stride, so the modulo is a mask
    logic [31:0]      sel_sum;
    logic [ROW_W-1:0] stride_d, start_row_d;
    assign sel_sum     = sel_rd[0] + 32'(dec.off);
    assign stride_d    = dec.quad ? ROW_W'(ROWS / 4) : ROW_W'(ROWS / 2);
    assign start_row_d = sel_sum[ROW_W-1:0] & (stride_d - ROW_W'(1));

    // Datapath for the row being written
    assign row = start_row_q + ROW_W'(ROW_W'(step_q) * stride_q);

    vadd_lane_add #(.VL(VL)) u_add (
        .a(src_q[step_q]), .b(zm_q), .wide(wide_q), .sum(sum)
    );

    // Accumulator array: the unit's own write takes priority
    logic             acc_we_m;
    logic [ROW_W-1:0] acc_wa_m;
    logic [VL-1:0]    acc_wd_m;
    logic [0:0][ROW_W-1:0] acc_ra;
    logic [0:0][VL-1:0]    acc_rd;
    assign acc_we_m  = busy_q | acc_we;
    assign acc_wa_m  = busy_q ? row : acc_waddr;
    assign acc_wd_m  = busy_q ? sum : acc_wdata;
    assign acc_ra[0] = acc_raddr;
    assign acc_rdata = acc_rd[0];

    vadd_bank #(.DEPTH(ROWS), .WIDTH(VL), .NRD(1)) u_acc (
        .clk(clk), .rst(rst), .we(acc_we_m), .waddr(acc_wa_m), .wdata(acc_wd_m),
        .raddr(acc_ra), .rdata(acc_rd)
    );

    // Control
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q      <= 1'b0;
            done_q      <= 1'b0;
            illegal_q   <= 1'b0;
            undef_q     <= 1'b0;
            wide_q      <= 1'b0;
            step_q      <= '0;
            last_q      <= '0;
            start_row_q <= '0;
            stride_q    <= '0;
            zm_q        <= '0;
            for (int k = 0; k < MAXG; k++) src_q[k] <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                illegal_q <= !dec.match;
                undef_q   <= dec.match && dec.wide && !SUPPORT_64;
                if (go) begin
                    busy_q      <= 1'b1;
                    step_q      <= '0;
                    last_q      <= dec.quad ? 2'd3 : 2'd1;
                    wide_q      <= dec.wide;
                    start_row_q <= start_row_d;
                    stride_q    <= stride_d;
                    zm_q        <= zr_rd[MAXG];
                    for (int k = 0; k < MAXG; k++) src_q[k] <= zr_rd[k];
                end else begin
                    done_q <= 1'b1;
                end
            end else if (busy_q) begin
                step_q <= step_q + 2'd1;
                if (step_q == last_q) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign illegal = illegal_q;
    assign undef   = undef_q;

    // Assertions
    assert_reject_R1: assert property (@(posedge clk) disable iff (rst)
        (accept && !dec.match) |=> (done_q && illegal_q && !busy_q));

    assert_undef_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && dec.match && dec.wide && !SUPPORT_64) |=> (done_q && undef_q && !busy_q));

    assert_stride_R5: assert property (@(posedge clk) disable iff (rst)
        (busy_q && step_q != 2'd0) |-> (row == ROW_W'($past(row) + stride_q)));

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> !done_q);

    assert_finish_R9: assert property (@(posedge clk) disable iff (rst)
        (busy_q && step_q == last_q) |=> (!busy_q && done_q));

    assert_group_R2: assert property (@(posedge clk) disable iff (rst)
        go |=> (busy_q && step_q == 2'd0 && (last_q == 2'd1 || last_q == 2'd3)));
endmodule

// File: tb/sim_mvec_add_unit.sv
module sim_mvec_add_unit;
    localparam int CLK_PERIOD = 10;
    localparam int VL    = 128;
    localparam int ROWS  = VL / 8;
    localparam int ROW_W = $clog2(ROWS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic start = 0; logic [31:0] instr = '0;
    logic busy, done, illegal, undef;
    logic zr_we = 0; logic [4:0] zr_waddr = '0; logic [VL-1:0] zr_wdata = '0;
    logic [4:0] zr_raddr = '0; logic [VL-1:0] zr_rdata;
    logic sel_we = 0; logic [1:0] sel_waddr = '0; logic [31:0] sel_wdata = '0;
    logic [1:0] sel_raddr = '0; logic [31:0] sel_rdata;
    logic [ROW_W-1:0] acc_raddr = '0; logic [VL-1:0] acc_rdata;

    logic start1 = 0; logic [31:0] instr1 = '0;
    logic busy1, done1, illegal1, undef1;
    logic [VL-1:0] zr_rdata1, acc_rdata1; logic [31:0] sel_rdata1;

    mvec_add_unit #(.VL(VL), .SUPPORT_64(1'b1)) u0 (
        .clk(clk), .rst(rst), .start(start), .instr(instr),
        .busy(busy), .done(done), .illegal(illegal), .undef(undef),
        .zr_we(zr_we), .zr_waddr(zr_waddr), .zr_wdata(zr_wdata),
        .zr_raddr(zr_raddr), .zr_rdata(zr_rdata),
        .sel_we(sel_we), .sel_waddr(sel_waddr), .sel_wdata(sel_wdata),
        .sel_raddr(sel_raddr), .sel_rdata(sel_rdata),
        .acc_we(1'b0), .acc_waddr('0), .acc_wdata('0),
        .acc_raddr(acc_raddr), .acc_rdata(acc_rdata)
    );

    mvec_add_unit #(.VL(VL), .SUPPORT_64(1'b0)) u1 (
        .clk(clk), .rst(rst), .start(start1), .instr(instr1),
        .busy(busy1), .done(done1), .illegal(illegal1), .undef(undef1),
        .zr_we(zr_we), .zr_waddr(zr_waddr), .zr_wdata(zr_wdata),
        .zr_raddr(zr_raddr), .zr_rdata(zr_rdata1),
        .sel_we(sel_we), .sel_waddr(sel_waddr), .sel_wdata(sel_wdata),
        .sel_raddr(sel_raddr), .sel_rdata(sel_rdata1),
        .acc_we(1'b0), .acc_waddr('0), .acc_wdata('0),
        .acc_raddr(acc_raddr), .acc_rdata(acc_rdata1)
    );

    int checks = 0, fails = 0;
    bit finished = 0;
    logic [VL-1:0] mz [32];
    logic [31:0]   ms [4];
    logic [VL-1:0] ma [ROWS];

    task automatic chk(input bit ok, input string tag, input logic [VL-1:0] act, input logic [VL-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit quad, bit sz, int zm, int rv, int zn, int off);
        return {9'b110000010, sz, 1'b1, quad, 4'(zm), 1'b0, 2'(rv), 3'b110, 5'(zn), 2'b10, 3'(off)};
    endfunction

    function automatic logic [VL-1:0] vsum(logic [VL-1:0] a, logic [VL-1:0] b, bit sz);
        logic [VL-1:0] r;
        for (int c = 0; c < VL/64; c++) begin
            if (sz) r[c*64 +: 64] = a[c*64 +: 64] + b[c*64 +: 64];
            else begin
                r[c*64 +: 32]    = a[c*64 +: 32] + b[c*64 +: 32];
                r[c*64+32 +: 32] = a[c*64+32 +: 32] + b[c*64+32 +: 32];
            end
        end
        return r;
    endfunction

    function automatic logic [VL-1:0] pat(int i);
        logic [VL-1:0] v;
        for (int w = 0; w < VL/32; w++) v[w*32 +: 32] = 32'h9E3779B9 * 32'(i*4 + w + 1);
        if (i % 3 == 0) v[31:0] = 32'hFFFF_FFFF;
        return v;
    endfunction

    task automatic check_rows(input string tag);
        for (int i = 0; i < ROWS; i++) begin
            acc_raddr = ROW_W'(i); #1;
            chk(acc_rdata === ma[i], tag, acc_rdata, ma[i]);
        end
    endtask

    task automatic write_zr(input int i, input logic [VL-1:0] v);
        @(negedge clk); zr_we = 1; zr_waddr = 5'(i); zr_wdata = v;
        @(negedge clk); zr_we = 0; mz[i] = v;
    endtask

    task automatic write_sel(input int i, input logic [31:0] v);
        @(negedge clk); sel_we = 1; sel_waddr = 2'(i); sel_wdata = v;
        @(negedge clk); sel_we = 0; ms[i] = v;
    endtask

    task automatic do_add(input bit quad, input bit sz, input int zm, input int rv,
                          input int zn, input int off, input bit disturb);
        logic [VL-1:0] ea [ROWS];
        int g, stride, st, k;
        longint s;
        g = quad ? 4 : 2; stride = ROWS / g;
        s = longint'(ms[rv]) + longint'(off);
        st = int'(s % longint'(stride));
        ea = ma;
        for (int r = 0; r < g; r++) ea[st + r*stride] = vsum(mz[(zn + r) % 32], mz[zm], sz);
        @(negedge clk); instr = mk(quad, sz, zm, rv, zn, off); start = 1;
        @(negedge clk); start = 0;
        chk(busy === 1'b1 && done === 1'b0, "R9 busy after accepted start", {126'b0, busy, done}, 128'b10);
        acc_raddr = ROW_W'(st);
        k = 0;
        while (!done && k < 12) begin
            @(negedge clk); k++;
            if (k == 1) begin
                #1 chk(acc_rdata === ea[st], "R9 first row one cycle after start", acc_rdata, ea[st]);
                if (disturb) begin
                    zr_we = 1; zr_waddr = 5'(zn); zr_wdata = ~mz[zn];
                    sel_we = 1; sel_waddr = 2'(rv); sel_wdata = ms[rv] + 32'd3;
                    start = 1; instr = mk(!quad, !sz, (zm + 1) % 16, rv, zn + 1, off ^ 1);
                end
            end
            if (k == 2) begin zr_we = 0; sel_we = 0; start = 0; end
        end
        chk(k == g, "R9 done after group size cycles", 128'(k), 128'(g));
        chk(illegal === 1'b0 && undef === 1'b0, "R1 flags clear on legal word", {126'b0, illegal, undef}, '0);
        if (disturb) begin mz[zn] = ~mz[zn]; ms[rv] = ms[rv] + 32'd3; end
        @(negedge clk);
        chk(done === 1'b0 && busy === 1'b0, "R9 done is one pulse", {126'b0, done, busy}, '0);
        ma = ea;
        check_rows(disturb ? "R10 result from start-time snapshot" : "R5 R6 R7 R3 row contents");
    endtask

    task automatic do_bad(input logic [31:0] w, input string tag);
        @(negedge clk); instr = w; start = 1;
        @(negedge clk); start = 0;
        chk(done === 1'b1 && illegal === 1'b1 && busy === 1'b0, tag, {125'b0, done, illegal, busy}, 128'b110);
        @(negedge clk);
        chk(done === 1'b0, "R1 reject done is one pulse", {127'b0, done}, '0);
        check_rows("R1 rejected word writes no row");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ROWS; i++) ma[i] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        chk(busy === 0 && done === 0 && illegal === 0 && undef === 0, "R11 reset flags",
            {124'b0, busy, done, illegal, undef}, '0);
        zr_raddr = 5'd17; sel_raddr = 2'd2; #1;
        chk(zr_rdata === '0 && sel_rdata === '0, "R11 reset registers", zr_rdata, '0);
        check_rows("R11 reset array");

        for (int i = 0; i < 32; i++) write_zr(i, pat(i));
        write_sel(0, 32'd0);
        write_sel(1, 32'd5);
        write_sel(2, 32'hFFFF_FFFF);
        write_sel(3, 32'h7FFF_FFFD);
        zr_raddr = 5'd7; sel_raddr = 2'd2; #1;
        chk(zr_rdata === mz[7], "R6 register preload readback", zr_rdata, mz[7]);
        chk(sel_rdata === ms[2], "R4 select preload readback", 128'(sel_rdata), 128'(ms[2]));

        // Sweep: group size, lane width, immediate, select register
        for (int q = 0; q < 2; q++)
            for (int sz = 0; sz < 2; sz++)
                for (int off = 0; off < 8; off++)
                    for (int rv = 0; rv < 4; rv++)
                        do_add(q[0], sz[0], (off + rv*3 + q) % 16, rv,
                               (off*5 + rv*7 + 28 + sz) % 32, off, 1'b0);

        // Register group wrap past 31
        do_add(1'b1, 1'b0, 15, 2, 31, 7, 1'b0);
        do_add(1'b1, 1'b1, 0, 3, 30, 6, 1'b0);
        do_add(1'b0, 1'b0, 9, 1, 31, 2, 1'b0);

        // Snapshot and start while busy
        do_add(1'b0, 1'b0, 4, 1, 12, 3, 1'b1);
        do_add(1'b1, 1'b1, 8, 2, 20, 5, 1'b1);
        do_add(1'b1, 1'b0, 8, 2, 20, 1, 1'b0);

        // R1 each fixed bit flipped; R2 bad group codes
        begin
            logic [31:0] base;
            int fixed_bits [15] = '{31,30,29,28,27,26,25,24,23,15,12,11,10,4,3};
            base = mk(1'b0, 1'b0, 3, 0, 6, 1);
            foreach (fixed_bits[j]) do_bad(base ^ (32'd1 << fixed_bits[j]), "R1 fixed bit mismatch");
            do_bad({base[31:22], 2'b00, base[19:0]}, "R2 group code 00 rejected");
            do_bad({base[31:22], 2'b01, base[19:0]}, "R2 group code 01 rejected");
        end
        do_add(1'b0, 1'b1, 2, 0, 1, 0, 1'b0);

        // R8 on the build without 64-bit lanes
        @(negedge clk); instr1 = mk(1'b1, 1'b1, 1, 0, 2, 0); start1 = 1;
        @(negedge clk); start1 = 0;
        chk(done1 === 1'b1 && undef1 === 1'b1 && illegal1 === 1'b0 && busy1 === 1'b0,
            "R8 undefined 64-bit request", {124'b0, done1, undef1, illegal1, busy1}, 128'b1100);
        @(negedge clk);
        for (int i = 0; i < ROWS; i++) begin
            acc_raddr = ROW_W'(i); #1;
            chk(acc_rdata1 === '0, "R8 undefined request writes no row", acc_rdata1, '0);
        end
        @(negedge clk); instr1 = mk(1'b0, 1'b0, 1, 0, 2, 0); start1 = 1;
        @(negedge clk); start1 = 0;
        chk(busy1 === 1'b1 && undef1 === 1'b0, "R8 32-bit lanes still run", {126'b0, busy1, undef1}, 128'b10);
        repeat (3) @(negedge clk);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule